// File: doc/BRIEF.md
# Range-Adaptive Sequential Booth Multiplier

This block multiplies two 16-bit two's-complement operands into a 32-bit product with a clocked radix-2 Booth loop. Each loop pass performs at most one add or subtract and then one arithmetic right shift. The number of passes is not fixed. When a start strobe is accepted, the block groups each operand into 4-bit slices. It finds the most significant nonzero slice of each operand and keeps the wider of the two results as the working range. Small positive operands therefore finish in far fewer cycles than full-width ones.

The range code is held on an output for the whole run. A busy flag covers the run, and a one-cycle done pulse marks the cycle in which a new product appears. Any negative operand has a nonzero top slice, so it always runs at full width as a signed product. In the reduced ranges, the multiplier is treated as zero-extended by one guard bit. One extra pass keeps a positive operand exact even when the top bit of its selected slice is set.

Top module: `rng_booth_mul`

## Requirements
- R1: The range code of an operand is the index of its most significant nonzero 4-bit slice: 3 for bits [15:12], 2 for [11:8], 1 for [7:4], and 0 for [3:0] or for an all-zero operand.
- R2: The working range is the larger of the two operand codes. It appears on `range_o` from the cycle after the accepted start and stays there until the next accepted start.
- R3: Counted from the clock edge that accepts start, `done` rises on edge 5, 9, 13 or 16 for working range 0, 1, 2 or 3.
- R4: When `done` is high, `p` equals the signed 16×16 product of `a` and `b` as sampled at the accepted start. This includes the extremes -32768 × -32768 = 1073741824 and -32768 × 32767.
- R5: An operand with bit 15 set forces working range 3, and the product is signed.
- R6: `done` is high for exactly one cycle per run. `busy` rises on the accepted start edge and falls on the same edge that raises `done`.
- R7: A start asserted while `busy` is high is ignored. The product, the range code and the run length of the current run are unchanged.
- R8: After reset, `p` is 0, `range_o` is 0, and `done` and `busy` are low. `p` changes only on the edge that raises `done` and holds its value afterwards.
- R9: A positive operand whose selected slice has its top bit set, such as 8 in range 0 or 255 in range 1, still gives the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| a | input | 16 | Multiplicand, two's complement |
| b | input | 16 | Multiplier, two's complement |
| p | output | 32 | Product register |
| done | output | 1 | One-cycle pulse when `p` is updated |
| busy | output | 1 | High while passes are running |
| range_o | output | 2 | Working range code of the current or last run |

## Verification
The bench aims at the guard pass. A design without it would return a negative or truncated product for 8 × 8 in range 0, or for 255 × 200 in range 1. It also exercises the most negative operand. With a 16-bit accumulator, -32768 × -32768 would wrap its intermediate subtraction and return a wrong sign. Mixed-range pairs are run both ways round. A design that took the range of only one operand would stop early and return a truncated product, and its `range_o` and run length would show the mismatch. A second start fired mid-run shows whether a design wrongly reloads its operands or restarts its counter.

// File: rtl/booth_pkg.sv
package booth_pkg;
   typedef enum logic [1:0] {
      BOP_HOLD = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;
endpackage

// File: rtl/bmul_range_det.sv
module bmul_range_det #(
   parameter int W  = 16,
   parameter int G  = 4,
   localparam int NG = W / G,
   localparam int RW = $clog2(NG)
) (
   input  logic [W-1:0]  opnd,
   output logic [RW-1:0] code
);
   logic [NG-1:0] grp_any;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      assign grp_any[g] = |opnd[g*G +: G];
   end

   // ascending scan: the highest nonzero slice wins
   always_comb begin
      code = '0;
      for (int i = 0; i < NG; i++) begin
         if (grp_any[i]) code = RW'(i);
      end
   end
endmodule

// File: rtl/bmul_pass_ctr.sv
module bmul_pass_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          en,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (en && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/bmul_datapath.sv
module bmul_datapath
   import booth_pkg::*;
#(
   parameter int W    = 16,
   localparam int SHW = $clog2(W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   input  logic [SHW-1:0] shamt,
   output logic [2*W-1:0] prod_nx
);
   logic signed [W:0]   acc_q, m_q, sum;
   logic [W-1:0]        q_q, q_nx;
   logic                qm1_q;
   logic signed [W:0]   acc_nx;
   logic signed [2*W:0] wide, shifted;
   booth_op_e           op;

   always_comb begin
      unique case ({q_q[0], qm1_q})
         2'b01:   op = BOP_ADD;
         2'b10:   op = BOP_SUB;
         default: op = BOP_HOLD;
      endcase
      unique case (op)
         BOP_ADD: sum = acc_q + m_q;
         BOP_SUB: sum = acc_q - m_q;
         default: sum = acc_q;
      endcase
      acc_nx  = {sum[W], sum[W:1]};
      q_nx    = {sum[0], q_q[W-1:1]};
      wide    = {acc_nx, q_nx};
      shifted = wide >>> shamt;
      prod_nx = shifted[2*W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         q_q   <= '0;
         qm1_q <= 1'b0;
         m_q   <= '0;
      end else if (load) begin
         acc_q <= '0;
         q_q   <= mplier;
         qm1_q <= 1'b0;
         m_q   <= {mcand[W-1], mcand};
      end else if (step) begin
         acc_q <= acc_nx;
         q_q   <= q_nx;
         qm1_q <= q_q[0];
      end
   end
endmodule

// File: rtl/rng_booth_mul.sv
module rng_booth_mul #(
   parameter int W    = 16,
   parameter int G    = 4,
   localparam int NG  = W / G,
   localparam int RW  = $clog2(NG),
   localparam int CW  = $clog2(W),
   localparam int SHW = $clog2(W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p,
   output logic           done,
   output logic           busy,
   output logic [RW-1:0]  range_o
);
   if (G < 1 || W % G != 0 || NG < 2) begin : g_bad_cfg
      $error("rng_booth_mul: W must be a multiple of G with at least two slices");
   end

   logic [RW-1:0]  rng_a, rng_b, rng_w, rng_q;
   logic [CW-1:0]  pass_m1;
   logic [SHW-1:0] sh_w, sh_q;
   logic           go, last, busy_q, done_q;
   logic [2*W-1:0] prod_nx, p_q;

   bmul_range_det #(.W(W), .G(G)) u_rng_a (.opnd(a), .code(rng_a));
   bmul_range_det #(.W(W), .G(G)) u_rng_b (.opnd(b), .code(rng_b));

   assign rng_w = (rng_a > rng_b) ? rng_a : rng_b;
   assign go    = start && !busy_q;

   // n data bits plus one guard pass below full width
   always_comb begin
      int n;
      n = G * (int'(rng_w) + 1);
      if (n < W) begin
         pass_m1 = CW'(n);
         sh_w    = SHW'(W - n - 1);
      end else begin
         pass_m1 = CW'(W - 1);
         sh_w    = '0;
      end
   end

   bmul_pass_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(go), .load_val(pass_m1),
      .en(busy_q), .last(last)
   );

   bmul_datapath #(.W(W)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(go), .step(busy_q),
      .mcand(a), .mplier(b), .shamt(sh_q), .prod_nx(prod_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rng_q  <= '0;
         sh_q   <= '0;
         p_q    <= '0;
      end else begin
         done_q <= busy_q && last;
         if (go) begin
            busy_q <= 1'b1;
            rng_q  <= rng_w;
            sh_q   <= sh_w;
         end else if (busy_q && last) begin
            busy_q <= 1'b0;
            p_q    <= prod_nx;
         end
      end
   end

   assign p       = p_q;
   assign done    = done_q;
   assign busy    = busy_q;
   assign range_o = rng_q;
endmodule

// File: rtl/bmul_chk.sv
module bmul_chk #(
   parameter int W    = 16,
   parameter int G    = 4,
   localparam int NG  = W / G,
   localparam int RW  = $clog2(NG)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [W-1:0]   a,
   input logic [W-1:0]   b,
   input logic [2*W-1:0] p,
   input logic           done,
   input logic           busy,
   input logic [RW-1:0]  range_o
);
   int unsigned run_cyc;
   int          exp_pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_cyc <= 0;
      else if (start && !busy) run_cyc <= 0;
      else if (busy)           run_cyc <= run_cyc + 1;
   end

   always_comb begin
      exp_pass = G * (int'(range_o) + 1) + 1;
      if (exp_pass > W) exp_pass = W;
   end

   assert_pass_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cyc == exp_pass));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_range_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(range_o));

   assert_p_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(p));

   assert_neg_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (a[W-1] || b[W-1])) |=> (range_o == '1));
endmodule

bind rng_booth_mul bmul_chk #(.W(W), .G(G)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .p(p),
   .done(done), .busy(busy), .range_o(range_o)
);

// File: tb/rng_booth_mul_tb.sv
module rng_booth_mul_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] a = '0, b = '0;
   logic [31:0] p;
   logic        done, busy;
   logic [1:0]  range_o;
   int          checks = 0, errors = 0;

   always #4 clk = ~clk;

   rng_booth_mul u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .p(p),
      .done(done), .busy(busy), .range_o(range_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int slice_code(input logic [15:0] v);
      if (|v[15:12]) return 3;
      if (|v[11:8])  return 2;
      if (|v[7:4])   return 1;
      return 0;
   endfunction

   task automatic run_mul(input logic [15:0] x, input logic [15:0] y,
                          input string req, input bit intrude);
      longint e;
      int     er, el, n, gaps;
      logic [31:0] p_keep;
      e  = longint'($signed(x)) * longint'($signed(y));
      er = slice_code(x) > slice_code(y) ? slice_code(x) : slice_code(y);
      el = (er == 3) ? 16 : 4 * (er + 1) + 1;
      @(negedge clk);
      a = x; b = y; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R6", "busy after start", longint'(busy), 1);
      chk(range_o == 2'(er), "R1 R2", "range code", longint'(range_o), longint'(er));
      n = 0; gaps = 0;
      while (!done && n < 100) begin
         if (!busy) gaps++;
         if (intrude && n == 2) begin
            a = 16'h7fff; b = 16'h8000; start = 1'b1;
         end
         @(posedge clk);
         n++;
         @(negedge clk);
         start = 1'b0;
      end
      chk(n == el, "R3", "cycles to done", longint'(n), longint'(el));
      chk(longint'($signed(p)) == e, req, "product", longint'($signed(p)), e);
      chk(busy == 1'b0 && gaps == 0, "R6", "busy span", longint'(gaps), 0);
      if (intrude)
         chk(range_o == 2'(er), "R7", "range after ignored start", longint'(range_o), longint'(er));
      p_keep = p;
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R6", "done width", longint'(done), 0);
      chk(p == p_keep, "R8", "product hold", longint'(p), longint'(p_keep));
   endtask

   task automatic t_reset();
      chk(p == 32'd0, "R8", "reset p", longint'(p), 0);
      chk(done == 1'b0 && busy == 1'b0, "R8", "reset flags", longint'({done, busy}), 0);
      chk(range_o == 2'd0, "R8", "reset range", longint'(range_o), 0);
   endtask

   task automatic t_each_range();   // R1, R4 across all four codes
      run_mul(16'd6, 16'd7, "R4", 1'b0);
      run_mul(16'd95, 16'd58, "R4", 1'b0);
      run_mul(16'd1347, 16'd510, "R4", 1'b0);
      run_mul(16'd22477, 16'd13632, "R4", 1'b0);
   endtask

   task automatic t_guard();        // R9
      run_mul(16'd8, 16'd8, "R9", 1'b0);
      run_mul(16'd15, 16'd9, "R9", 1'b0);
      run_mul(16'd255, 16'd200, "R9", 1'b0);
      run_mul(16'd4095, 16'd2048, "R9", 1'b0);
   endtask

   task automatic t_negative();     // R5
      run_mul(16'hffff, 16'd1, "R5", 1'b0);
      run_mul(16'd3, 16'hfff9, "R5", 1'b0);
      run_mul(-16'sd5, 16'd3000, "R5", 1'b0);
   endtask

   task automatic t_extremes();     // R4
      run_mul(16'h8000, 16'h8000, "R4", 1'b0);
      run_mul(16'h8000, 16'h7fff, "R4", 1'b0);
      run_mul(16'h7fff, 16'h7fff, "R4", 1'b0);
      run_mul(16'd0, 16'h8000, "R4", 1'b0);
   endtask

   task automatic t_mixed();        // R2
      run_mul(16'h000f, 16'h0f00, "R2", 1'b0);
      run_mul(16'h0f00, 16'h000f, "R2", 1'b0);
      run_mul(16'd0, 16'd0, "R2", 1'b0);
      run_mul(16'd1, 16'h1000, "R2", 1'b0);
   endtask

   task automatic t_busy_start();   // R7
      run_mul(16'd100, 16'd200, "R7", 1'b1);
   endtask

   task automatic t_hold();         // R8
      logic [31:0] keep;
      keep = p;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(p == keep && done == 1'b0, "R8", "idle hold", longint'(p), longint'(keep));
      end
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_each_range();
      t_guard();
      t_negative();
      t_extremes();
      t_mixed();
      t_busy_start();
      t_hold();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule